// File: doc/BRIEF.md
# Indexed Operand Address Generator

This block turns an indexed-addressing postbyte into the effective operand address for a 16-bit microcontroller core. The core presents the postbyte and up to two extension bytes. It also presents the four index-capable registers (X, Y, SP, PC), the two 8-bit accumulators A and B, and a restricted-mode flag. It then pulses `start` for one cycle. The block holds its inputs' result in registers and raises `done` for one cycle once the address is final.

Along with the address, the block reports three things the core needs. The first is the index register to update for auto-increment and auto-decrement forms. The second is whether the mode costs one extra cycle. The third is how many extension bytes the mode used, so the fetch unit can advance the PC.

The two indirect forms read a 16-bit pointer through a request/valid port. `rd_req` stays high with a stable address until `rd_valid` returns the pointer, and that pointer becomes the effective address. When restricted mode is set, the forms that take a 16-bit offset indirect or a 9- or 16-bit constant offset are reported as illegal and produce no address.

Top module: `idx_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `done`, `rd_req` and `wb_en` are 0 and `ea` is 0.
- R2: Postbyte bit 5 = 0 selects base register bits 7:6 (0=X, 1=Y, 2=SP, 3=PC) and adds the signed offset in bits 4:0 (sign bit 4). It uses 0 extension bytes, no extra cycle and no write-back.
- R3: Postbyte bit 5 = 1 with bits 7:6 ≠ 3 is auto-modify. The step is the low nibble minus 16 when nibble bit 3 is set (−8..−1), else the nibble plus 1 (+1..+8). The done cycle has `wb_en`=1, `wb_sel`=bits 7:6 and `wb_data`=base+step.
- R4: In auto-modify, bit 4 = 0 gives `ea` = base+step (pre-modify) and bit 4 = 1 gives `ea` = the unmodified base (post-modify).
- R5: Postbyte bits 7:5 = 111 take the base from bits 4:3. If bits 2:0 ≠ 011 and bit 2 = 0, the offset is a constant with one extra cycle. With bit 1 = 1 it is the 16-bit value {ext_b0, ext_b1} (length 2). With bit 1 = 0 it is ext_b0 sign-extended by postbyte bit 0 (length 1).
- R6: Postbyte 111xx1ab with ab ≠ 11 adds an accumulator: ab=00 adds zero-extended A, 01 adds zero-extended B, 10 adds D={A,B}. It uses 0 extension bytes and no extra cycle.
- R7: Postbyte 111xx011 reads a pointer at base+{ext_b0, ext_b1}. `ea` is the returned pointer, with `ext_len`=2 and `extra_cycle`=1.
- R8: Postbyte 111xx111 reads a pointer at base+D. `ea` is the returned pointer, with `ext_len`=0 and `extra_cycle`=1.
- R9: With `restricted`=1, the forms in R7 and R5 end with `illegal`=1, `ea`=0, `wb_en`=0, `ext_len`=0, `extra_cycle`=0, and no memory request.
- R10: A direct mode raises `done` one cycle after `start`. An indirect mode raises `rd_req` one cycle after `start` and holds `rd_req` and `rd_addr` stable until `rd_valid`. `done` then rises the next cycle with `rd_req` low. A `start` while a read is pending is ignored.
- R11: All address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to decode the presented postbyte |
| postbyte | input | 8 | Indexed-mode postbyte |
| ext_b0 | input | 8 | First extension byte after the postbyte |
| ext_b1 | input | 8 | Second extension byte |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter value used as base |
| acc_a | input | 8 | Accumulator A (high byte of D) |
| acc_b | input | 8 | Accumulator B (low byte of D) |
| restricted | input | 1 | Forbid the long-offset and offset-indirect forms |
| rd_req | output | 1 | Pointer read request, held until `rd_valid` |
| rd_addr | output | 16 | Pointer read address |
| rd_valid | input | 1 | Pointer read data is valid |
| rd_data | input | 16 | Pointer read data |
| done | output | 1 | One-cycle strobe: result fields are final |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Write `wb_data` to register `wb_sel` (valid with `done`) |
| wb_sel | output | 2 | Register to update (0=X, 1=Y, 2=SP, 3=PC) |
| wb_data | output | 16 | Updated index register value |
| extra_cycle | output | 1 | Mode costs one extra cycle |
| illegal | output | 1 | Mode is not allowed in restricted mode |
| ext_len | output | 2 | Extension bytes consumed (0, 1 or 2) |

## Verification
On every cycle, the assertions check the handshake. Once a pointer request is raised, its address stays stable until it is answered. A `start` is always followed by either a request or `done`, and an answered read produces `done` with the request dropped. An illegal result never carries a write-back, an extension length or an extra cycle, and the reported length never reaches 3.

The arithmetic can only be shown by the bench's sweep. This covers the chosen base register, the sign-extended offsets, the auto-modify step and its pre/post choice, the accumulator zero-extension, wrap-around near 0 and 0xFFFF, and the pointer taken from memory. The sweep drives all 256 postbytes, in both restricted settings, against two register sets.

// File: rtl/idx_pkg.sv
// Shared types for the indexed operand address generator.
// Assumes a 16-bit address space and 8-bit postbyte/extension bytes.
package idx_pkg;
    localparam int AW = 16;
    localparam int BW = 8;
    localparam int NREG = 4;
    localparam int SELW = $clog2(NREG);

    typedef enum logic [2:0] {
        MD_OFF5,
        MD_AUTO,
        MD_IND16,
        MD_CONST,
        MD_ACC
    } idx_mode_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } idx_state_e;

    typedef struct packed {
        idx_mode_e       mode;
        logic [SELW-1:0] base_sel;
        logic            post;
        logic [1:0]      ext_len;
        logic            extra;
        logic            indirect;
        logic            illegal;
        logic            wb;
    } idx_dec_t;
endpackage

// File: rtl/idx_decode.sv
// Postbyte classifier: decides the mode, the base register, the number of
// extension bytes, the extra-cycle charge and legality.
// Assumes: purely combinational, inputs valid whenever they are used.
module idx_decode
    import idx_pkg::*;
(
    input  logic [BW-1:0] pb,
    input  logic          restricted,
    output idx_dec_t      dec
);
    // Classify the postbyte into one mode and its side information.
    always_comb begin
        dec          = '0;
        dec.mode     = MD_OFF5;
        dec.base_sel = pb[7:6];
        dec.post     = pb[4];
        if (!pb[5]) begin
            dec.mode = MD_OFF5;
        end else if (pb[7:6] != 2'b11) begin
            dec.mode = MD_AUTO;
            dec.wb   = 1'b1;
        end else begin
            dec.base_sel = pb[4:3];
            if (pb[2:0] == 3'b011) begin
                dec.mode = MD_IND16;
                if (restricted) begin
                    dec.illegal = 1'b1;
                end else begin
                    dec.ext_len  = 2'd2;
                    dec.extra    = 1'b1;
                    dec.indirect = 1'b1;
                end
            end else if (!pb[2]) begin
                dec.mode = MD_CONST;
                if (restricted) begin
                    dec.illegal = 1'b1;
                end else begin
                    dec.ext_len = pb[1] ? 2'd2 : 2'd1;
                    dec.extra   = 1'b1;
                end
            end else begin
                dec.mode = MD_ACC;
                if (pb[1:0] == 2'b11) begin
                    dec.extra    = 1'b1;
                    dec.indirect = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/idx_agu.sv
// Address arithmetic: selects the base register, forms the offset for the
// decoded mode, and produces the sum and the direct effective address.
// Assumes: dec comes from idx_decode for the same postbyte; sums wrap.
module idx_agu
    import idx_pkg::*;
(
    input  logic [BW-1:0]          pb,
    input  idx_dec_t               dec,
    input  logic [BW-1:0]          ext_b0,
    input  logic [BW-1:0]          ext_b1,
    input  logic [NREG-1:0][AW-1:0] regs,
    input  logic [BW-1:0]          acc_a,
    input  logic [BW-1:0]          acc_b,
    output logic [AW-1:0]          sum,
    output logic [AW-1:0]          direct_ea
);
    localparam int NIB = 4;
    localparam int OFF5 = 5;

    logic [AW-1:0] base;
    logic [AW-1:0] offset;
    logic [AW-1:0] step;

    // Base register pick.
    assign base = regs[dec.base_sel];

    // Auto-modify step: negative nibble sign-extends, else nibble plus one.
    assign step = pb[3] ? {{(AW-NIB){1'b1}}, pb[NIB-1:0]}
                        : AW'(pb[NIB-1:0]) + AW'(1);

    // Offset for each mode.
    always_comb begin
        unique case (dec.mode)
            MD_OFF5:  offset = {{(AW-OFF5){pb[4]}}, pb[OFF5-1:0]};
            MD_AUTO:  offset = step;
            MD_IND16: offset = AW'({ext_b0, ext_b1});
            MD_CONST: offset = pb[1] ? AW'({ext_b0, ext_b1})
                                     : {{(AW-BW){pb[0]}}, ext_b0};
            MD_ACC: begin
                unique case (pb[1:0])
                    2'b00:   offset = AW'(acc_a);
                    2'b01:   offset = AW'(acc_b);
                    default: offset = AW'({acc_a, acc_b});
                endcase
            end
            default:  offset = '0;
        endcase
    end

    // Modulo-2^AW sum and the post-modify choice.
    assign sum       = base + offset;
    assign direct_ea = (dec.mode == MD_AUTO && dec.post) ? base : sum;
endmodule

// File: rtl/idx_addr_gen.sv
// Top: captures one decode per start pulse, runs the pointer-read handshake
// for indirect modes and presents registered results with a done strobe.
// Assumes: inputs are valid in the start cycle only; start during a
// pending read is ignored; rd_data is valid in the rd_valid cycle.
module idx_addr_gen
    import idx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      postbyte,
    input  logic [7:0]      ext_b0,
    input  logic [7:0]      ext_b1,
    input  logic [15:0]     reg_x,
    input  logic [15:0]     reg_y,
    input  logic [15:0]     reg_sp,
    input  logic [15:0]     reg_pc,
    input  logic [7:0]      acc_a,
    input  logic [7:0]      acc_b,
    input  logic            restricted,
    output logic            rd_req,
    output logic [15:0]     rd_addr,
    input  logic            rd_valid,
    input  logic [15:0]     rd_data,
    output logic            done,
    output logic [15:0]     ea,
    output logic            wb_en,
    output logic [1:0]      wb_sel,
    output logic [15:0]     wb_data,
    output logic            extra_cycle,
    output logic            illegal,
    output logic [1:0]      ext_len
);
    idx_dec_t                dec;
    logic [NREG-1:0][AW-1:0] regs;
    logic [AW-1:0]           sum;
    logic [AW-1:0]           direct_ea;

    idx_state_e      state_q;
    logic            done_q;
    logic [AW-1:0]   ea_q;
    logic [AW-1:0]   ptr_q;
    logic            wb_q;
    logic [SELW-1:0] wb_sel_q;
    logic [AW-1:0]   wb_data_q;
    logic            extra_q;
    logic            ill_q;
    logic [1:0]      len_q;

    // Register file view in base-select order (0=X, 1=Y, 2=SP, 3=PC).
    assign regs = {reg_pc, reg_sp, reg_y, reg_x};

    idx_decode u_dec (
        .pb         (postbyte),
        .restricted (restricted),
        .dec        (dec)
    );

    idx_agu u_agu (
        .pb        (postbyte),
        .dec       (dec),
        .ext_b0    (ext_b0),
        .ext_b1    (ext_b1),
        .regs      (regs),
        .acc_a     (acc_a),
        .acc_b     (acc_b),
        .sum       (sum),
        .direct_ea (direct_ea)
    );

    // Capture results on start and sequence the pointer read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b0;
            ea_q      <= '0;
            ptr_q     <= '0;
            wb_q      <= 1'b0;
            wb_sel_q  <= '0;
            wb_data_q <= '0;
            extra_q   <= 1'b0;
            ill_q     <= 1'b0;
            len_q     <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        wb_q      <= dec.wb;
                        wb_sel_q  <= dec.base_sel;
                        wb_data_q <= sum;
                        extra_q   <= dec.extra;
                        ill_q     <= dec.illegal;
                        len_q     <= dec.ext_len;
                        if (dec.indirect) begin
                            ptr_q   <= sum;
                            state_q <= ST_WAIT;
                        end else begin
                            ea_q   <= dec.illegal ? '0 : direct_ea;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (rd_valid) begin
                        ea_q    <= rd_data;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output mapping.
    assign rd_req      = (state_q == ST_WAIT);
    assign rd_addr     = ptr_q;
    assign done        = done_q;
    assign ea          = ea_q;
    assign wb_en       = done_q & wb_q;
    assign wb_sel      = wb_sel_q;
    assign wb_data     = wb_data_q;
    assign extra_cycle = extra_q;
    assign illegal     = ill_q;
    assign ext_len     = len_q;
endmodule

// File: rtl/idx_addr_gen_chk.sv
// Protocol and result-consistency checker for idx_addr_gen, bound to it.
// Assumes: synchronous active-low reset; observes ports only.
module idx_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        rd_req,
    input logic [15:0] rd_addr,
    input logic        rd_valid,
    input logic        done,
    input logic        wb_en,
    input logic        illegal,
    input logic        extra_cycle,
    input logic [1:0]  ext_len
);
    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

    // R10
    start_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !rd_req |=> done || rd_req);

    // R10
    rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_valid |=> done && !rd_req);

    // R10
    done_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && illegal |-> !wb_en && ext_len == 2'd0 && !extra_cycle);

    // R3
    wb_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done && !illegal);

    // R5
    ext_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ext_len != 2'd3);
endmodule

bind idx_addr_gen idx_addr_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .rd_valid    (rd_valid),
    .done        (done),
    .wb_en       (wb_en),
    .illegal     (illegal),
    .extra_cycle (extra_cycle),
    .ext_len     (ext_len)
);

// File: tb/idx_addr_gen_tb.sv
// Sweeps every postbyte in both restricted settings over two register sets
// and compares against an arithmetic model written from the requirements.
module idx_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0;
    logic [7:0]  ext_b0 = '0;
    logic [7:0]  ext_b1 = '0;
    logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic        restricted = 1'b0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic        done;
    logic [15:0] ea;
    logic        wb_en;
    logic [1:0]  wb_sel;
    logic [15:0] wb_data;
    logic        extra_cycle;
    logic        illegal;
    logic [1:0]  ext_len;

    int tests = 0;
    int fails = 0;

    // expected values
    int    e_ea, e_wbd, e_rda, e_sel, e_len;
    bit    e_wb, e_extra, e_ill, e_ind;
    string e_req;

    always #4 clk = ~clk;

    idx_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
        .ext_b0(ext_b0), .ext_b1(ext_b1), .reg_x(reg_x), .reg_y(reg_y),
        .reg_sp(reg_sp), .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b),
        .restricted(restricted), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .ea(ea),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
        .extra_cycle(extra_cycle), .illegal(illegal), .ext_len(ext_len)
    );

    function automatic int mem_f(input int a);
        return ((((a & 255) << 8) | ((a >> 8) & 255)) ^ 32'h3C5A);
    endfunction

    function automatic int reg_of(input int s);
        case (s)
            0: return int'(reg_x);
            1: return int'(reg_y);
            2: return int'(reg_sp);
            default: return int'(reg_pc);
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model from the requirements.
    task automatic model(input bit [7:0] pb, input bit restr);
        int base, off, n, nv, b0, b1;
        b0 = int'(ext_b0); b1 = int'(ext_b1);
        e_ea = 0; e_wbd = 0; e_rda = 0; e_sel = 0; e_len = 0;
        e_wb = 0; e_extra = 0; e_ill = 0; e_ind = 0;
        if (pb[5] == 1'b0) begin
            base = reg_of(int'(pb[7:6]));
            off  = pb[4] ? int'(pb[4:0]) - 32 : int'(pb[4:0]);
            e_ea = (base + off) & 16'hFFFF;
            e_req = "R2";
        end else if (pb[7:6] != 2'b11) begin
            base = reg_of(int'(pb[7:6]));
            n    = int'(pb[3:0]);
            off  = (n >= 8) ? n - 16 : n + 1;
            nv   = (base + off) & 16'hFFFF;
            e_wb = 1; e_sel = int'(pb[7:6]); e_wbd = nv;
            e_ea = pb[4] ? base : nv;
            e_req = pb[4] ? "R4" : "R3";
        end else begin
            base = reg_of(int'(pb[4:3]));
            if (pb[2:0] == 3'b011) begin
                if (restr) begin e_ill = 1; e_req = "R9"; end
                else begin
                    e_ind = 1; e_extra = 1; e_len = 2;
                    e_rda = (base + b0 * 256 + b1) & 16'hFFFF;
                    e_ea  = mem_f(e_rda);
                    e_req = "R7";
                end
            end else if (pb[2] == 1'b0) begin
                if (restr) begin e_ill = 1; e_req = "R9"; end
                else begin
                    if (pb[1]) begin off = b0 * 256 + b1; e_len = 2; end
                    else begin off = pb[0] ? b0 - 256 : b0; e_len = 1; end
                    e_extra = 1;
                    e_ea = (base + off) & 16'hFFFF;
                    e_req = "R5";
                end
            end else begin
                case (pb[1:0])
                    2'b00:   off = int'(acc_a);
                    2'b01:   off = int'(acc_b);
                    default: off = int'(acc_a) * 256 + int'(acc_b);
                endcase
                if (pb[1:0] == 2'b11) begin
                    e_ind = 1; e_extra = 1;
                    e_rda = (base + off) & 16'hFFFF;
                    e_ea  = mem_f(e_rda);
                    e_req = "R8";
                end else begin
                    e_ea  = (base + off) & 16'hFFFF;
                    e_req = "R6";
                end
            end
        end
    endtask

    task automatic load_set(input int s);
        if (s == 0) begin
            reg_x = 16'h1000; reg_y = 16'h2000; reg_sp = 16'h3FF0;
            reg_pc = 16'h8000; acc_a = 8'h85; acc_b = 8'h7F;
        end else begin
            // R11: register values next to the wrap point
            reg_x = 16'hFFFE; reg_y = 16'h0001; reg_sp = 16'h0000;
            reg_pc = 16'hFFF8; acc_a = 8'hFF; acc_b = 8'h01;
        end
    endtask

    task automatic run_one(input int s, input bit restr, input bit [7:0] pb,
                           input bit poke);
        int cyc, wc, seen_rda;
        bit req_seen;
        string tag;
        tag = (s == 1) ? {e_req, "/R11"} : e_req;
        load_set(s);
        restricted = restr; postbyte = pb;
        ext_b0 = pb ^ 8'hA5; ext_b1 = pb + 8'h3C;
        model(pb, restr);
        tag = (s == 1) ? {e_req, "/R11"} : e_req;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; wc = 0; req_seen = 0; seen_rda = 0;
        while (!done && cyc < 20) begin
            if (rd_req) begin
                req_seen = 1; seen_rda = int'(rd_addr); wc++;
                if (poke && wc == 1) begin
                    postbyte = 8'h00; start = 1'b1;
                end
                if (wc == 2) begin
                    start = 1'b0; postbyte = pb;
                    rd_valid = 1'b1; rd_data = 16'(mem_f(int'(rd_addr)));
                end
            end
            @(negedge clk);
            rd_valid = 1'b0;
            cyc++;
        end
        // R10 latency: direct 0 extra negedges, indirect 2
        check(done == 1'b1 && cyc == (e_ind ? 2 : 0), "R10", "latency", cyc,
              e_ind ? 2 : 0);
        check(req_seen == e_ind && (!e_ind || seen_rda == e_rda), tag,
              "rd_addr", seen_rda, e_rda);
        check(int'(ea) == e_ea && illegal == e_ill && extra_cycle == e_extra
              && int'(ext_len) == e_len && wb_en == e_wb
              && (!e_wb || (int'(wb_sel) == e_sel && int'(wb_data) == e_wbd)),
              tag, $sformatf("pb=%02h ea/ill/ext/len/wb/wbd", pb),
              {ea, 3'(illegal), 3'(extra_cycle), 2'(ext_len), 1'(wb_en), wb_data},
              {16'(e_ea), 3'(e_ill), 3'(e_extra), 2'(e_len), 1'(e_wb), 16'(e_wbd)});
        if (poke) begin
            @(negedge clk);
            // R10: start during the pending read must not produce a result
            check(done == 1'b0 && rd_req == 1'b0, "R10", "ignored start",
                  int'(done), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done == 0 && rd_req == 0 && wb_en == 0 && ea == 0, "R1",
              "reset outputs", {done, rd_req, wb_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 2; s++)
            for (int r = 0; r < 2; r++)
                for (int p = 0; p < 256; p++)
                    run_one(s, r[0], p[7:0], 1'b0);
        run_one(0, 1'b0, 8'hE3, 1'b1);
        run_one(1, 1'b0, 8'hFF, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule